// File: doc/BRIEF.md
# Multiplicative Congruential Random Word Generator

This block produces a stream of pseudo-random 32-bit words. A 31-bit state is kept as a residue modulo the Mersenne prime 2^31−1. Each enabled clock cycle multiplies the state by the fixed constant 16807. The product is then reduced without a divider. The product is cut into the part below bit 31 and the part above it. Because 2^31 is congruent to 1 modulo 2^31−1, the two parts are added in a one's-complement style adder. That adder uses a parallel-prefix carry tree, and its carry out re-enters at bit 0.

Software-free use is expected. A client loads a seed, then raises the step enable whenever it wants a fresh word. It takes the word in the cycle where the valid flag is high. The two seeds that would trap the recurrence at zero are replaced by 1 when loaded.

Top module: `mcg_rng`

## Requirements
- R1: While reset is held and in the first cycle after it, the output word reads 1 and valid is low.
- R2: A load of any seed other than 0 and 0x7FFFFFFF makes the output word equal that seed in the next cycle, with valid low.
- R3: A load of seed 0 or seed 0x7FFFFFFF (all 31 bits set) makes the output word 1 in the next cycle.
- R4: A step without load makes the next output word equal to (16807 × previous word) mod (2^31−1). This holds also when the low 31 bits of the product are all ones.
- R5: Valid is high in exactly those cycles that follow a cycle with step high and load low.
- R6: With neither load nor step, the output word keeps its value and valid is low in the next cycle.
- R7: When load and step are both high, the load wins: the word becomes the sanitised seed and valid is low.
- R8: Output bit 31 is always 0, and after reset the word always lies in the range 1 to 2^31−2.
- R9: After loading seed 1 and stepping 10000 times, the output word is 1043618065.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load seed_i into the state this cycle |
| seed_i | input | 31 | Seed value |
| step_i | input | 1 | Advance the recurrence by one step |
| word_o | output | 32 | Current state, zero-extended |
| valid_o | output | 1 | High in the cycle after a step |

## Verification
The hardest case to reach from the ports is a product whose low 31 bits are all ones. There, the fold sum wraps through the end-around carry along the full carry tree. A random walk of the recurrence almost never lands on that case. The bench therefore computes the inverse of 16807 modulo 2^31 by Newton iteration, negates it to get a seed that forces that low half, loads that seed and takes one step. The lock-up seeds and the load-versus-step collision are driven directly, and a long run from seed 1 checks the accumulated result.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  localparam int STATE_W  = 31;
  localparam int WORD_W   = 32;
  localparam int MULT_W   = 16;
  localparam int MULT_DEF = 16807;

  // True for the two seeds that would trap the recurrence at residue zero.
  function automatic logic seed_locks(input logic [STATE_W-1:0] s);
    return (s == '0) || (s == '1);
  endfunction
endpackage

// File: rtl/mcg_cmul.sv
// Constant multiplier: a WORD_W-bit operand times a MULT_W-bit constant.
// Only the set bits of the constant produce a partial product.
module mcg_cmul #(
  parameter int A_W    = 32,
  parameter int K_W    = 16,
  parameter int K      = 16807,
  localparam int PROD_W = A_W + K_W
) (
  input  logic [A_W-1:0]    a_i,
  output logic [PROD_W-1:0] prod_o
);
  localparam logic [K_W-1:0] KBITS = K_W'(K);

  logic [PROD_W-1:0] pp [K_W];

  for (genvar i = 0; i < K_W; i++) begin : g_pp
    if (KBITS[i]) begin : g_on
      assign pp[i] = PROD_W'(a_i) << i;
    end else begin : g_off
      assign pp[i] = '0;
    end
  end

  always_comb begin
    prod_o = '0;
    for (int i = 0; i < K_W; i++) prod_o = prod_o + pp[i];
  end
endmodule

// File: rtl/mcg_eac_add.sv
// Modulo (2^W - 1) adder: Kogge-Stone prefix tree, end-around carry,
// all-ones result mapped to zero.
module mcg_eac_add #(
  parameter int W = 31,
  localparam int LV = $clog2(W)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         allones_o,
  output logic         cout_o
);
  logic [W-1:0] g0, p0, gpre, ppre, cin, raw;

  assign g0 = a_i & b_i;
  assign p0 = a_i ^ b_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    logic [W-1:0] gin, pin, gout, pout;
    if (l == 0) begin : g_first
      assign gin = g0;
      assign pin = p0;
    end else begin : g_next
      assign gin = g_lvl[l-1].gout;
      assign pin = g_lvl[l-1].pout;
    end
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= (1 << l)) begin : g_mix
        assign gout[i] = gin[i] | (pin[i] & gin[i-(1<<l)]);
        assign pout[i] = pin[i] & pin[i-(1<<l)];
      end else begin : g_pass
        assign gout[i] = gin[i];
        assign pout[i] = pin[i];
      end
    end
  end

  assign gpre   = g_lvl[LV-1].gout;
  assign ppre   = g_lvl[LV-1].pout;
  assign cout_o = gpre[W-1];

  // Carry out re-enters at bit 0; one extra level folds it in.
  assign cin[0] = cout_o;
  for (genvar i = 1; i < W; i++) begin : g_wrap
    assign cin[i] = gpre[i-1] | (ppre[i-1] & cout_o);
  end

  assign raw       = p0 ^ cin;
  assign allones_o = &raw;
  assign sum_o     = allones_o ? '0 : raw;
endmodule

// File: rtl/mcg_seed_fix.sv
module mcg_seed_fix
  import mcg_pkg::*;
#(
  parameter int W = STATE_W
) (
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] seed_o,
  output logic         fixed_o
);
  assign fixed_o = seed_locks(STATE_W'(seed_i));
  assign seed_o  = fixed_o ? W'(1) : seed_i;
endmodule

// File: rtl/mcg_rng.sv
module mcg_rng
  import mcg_pkg::*;
#(
  parameter int SW  = STATE_W,
  parameter int OW  = WORD_W,
  parameter int MW  = MULT_W,
  parameter int MUL = MULT_DEF
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [SW-1:0] seed_i,
  input  logic          step_i,
  output logic [OW-1:0] word_o,
  output logic          valid_o
);
  localparam int PW = OW + MW;
  localparam int HW = PW - SW;

  logic [SW-1:0] state_q, state_nxt, seed_clean, fold_lo, fold_hi;
  logic [PW-1:0] prod;
  logic          valid_q;

  // Named internal events for the checker.
  logic seed_fixed_w, fold_allones_w, fold_carry_w, adv_w;

  mcg_seed_fix #(.W(SW)) u_fix (
    .seed_i (seed_i),
    .seed_o (seed_clean),
    .fixed_o(seed_fixed_w)
  );

  mcg_cmul #(.A_W(OW), .K_W(MW), .K(MUL)) u_mul (
    .a_i   (OW'(state_q)),
    .prod_o(prod)
  );

  assign fold_lo = prod[SW-1:0];
  assign fold_hi = SW'(prod[PW-1 -: HW]);

  mcg_eac_add #(.W(SW)) u_add (
    .a_i      (fold_lo),
    .b_i      (fold_hi),
    .sum_o    (state_nxt),
    .allones_o(fold_allones_w),
    .cout_o   (fold_carry_w)
  );

  assign adv_w = step_i && !load_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= SW'(1);
      valid_q <= 1'b0;
    end else begin
      if (load_i)      state_q <= seed_clean;
      else if (step_i) state_q <= state_nxt;
      valid_q <= adv_w;
    end
  end

  assign word_o  = OW'(state_q);
  assign valid_o = valid_q;
endmodule

// File: rtl/mcg_rng_chk.sv
module mcg_rng_chk #(
  parameter int SW = 31,
  parameter int OW = 32
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          load_i,
  input logic          step_i,
  input logic [SW-1:0] seed_i,
  input logic [OW-1:0] word_o,
  input logic          valid_o,
  input logic          seed_fixed_w,
  input logic          fold_allones_w
);
  // R1: first cycle after reset
  p_reset_state_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (word_o == OW'(1)) && !valid_o);

  // R2
  p_load_seed_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i && !seed_fixed_w |=> (word_o == OW'($past(seed_i))) && !valid_o);

  // R3
  p_lock_seed_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i && (seed_i == '0 || seed_i == '1) |=> word_o == OW'(1));

  // R4: a nonzero residue times 16807 is never zero and never a fixed point
  p_no_zero_fold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i && !load_i |-> !fold_allones_w);
  p_moves_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i && !load_i |=> word_o != $past(word_o));

  // R5
  p_valid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i && !load_i |=> valid_o);

  // R6
  p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i && !load_i |=> $stable(word_o) && !valid_o);

  // R7
  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i && step_i |=> !valid_o);

  // R8
  p_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !word_o[OW-1] && (word_o[SW-1:0] != '0) && (word_o[SW-1:0] != '1));
endmodule

bind mcg_rng mcg_rng_chk #(.SW(SW), .OW(OW)) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .load_i        (load_i),
  .step_i        (step_i),
  .seed_i        (seed_i),
  .word_o        (word_o),
  .valid_o       (valid_o),
  .seed_fixed_w  (seed_fixed_w),
  .fold_allones_w(fold_allones_w)
);

// File: tb/sim_mcg_rng.sv
module sim_mcg_rng;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic        step = 1'b0;
  logic [30:0] seed = '0;
  logic [31:0] word;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mcg_rng u0 (
    .clk_i(clk), .rst_i(rst), .load_i(load), .seed_i(seed),
    .step_i(step), .word_o(word), .valid_o(valid)
  );

  localparam longint unsigned PRIME = 64'h7FFF_FFFF;

  function automatic longint unsigned nxt(input longint unsigned s);
    return (s * 64'd16807) % PRIME;
  endfunction

  function automatic longint unsigned clean(input logic [30:0] s);
    if (s == 31'd0 || s == 31'h7FFF_FFFF) return 64'd1;
    return 64'(s);
  endfunction

  // Inverse of 16807 modulo 2^32 by Newton iteration.
  function automatic logic [31:0] inv_k();
    logic [31:0] x = 32'd16807;
    for (int i = 0; i < 5; i++) x = x * (32'd2 - 32'd16807 * x);
    return x;
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Apply one cycle of inputs; returns after the edge, at the falling edge.
  task automatic cyc(input logic l, input logic [30:0] s, input logic st);
    load = l; seed = s; step = st;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected finished");
    finish_run();
  end

  initial begin
    longint unsigned m;
    logic [30:0] s;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk("R1 word in reset", word, 1);
    chk("R1 valid in reset", valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 word after reset", word, 1);

    cyc(1, 31'd12345, 0);
    chk("R2 load word", word, 12345);
    chk("R2 load valid", valid, 0);

    cyc(0, 0, 1);
    chk("R4 step word", word, nxt(12345));
    chk("R5 valid after step", valid, 1);

    cyc(0, 0, 0);
    chk("R6 hold word", word, nxt(12345));
    chk("R5 R6 valid idle", valid, 0);

    cyc(1, 31'd0, 0);
    chk("R3 seed zero", word, 1);
    cyc(1, 31'h7FFF_FFFF, 0);
    chk("R3 seed all ones", word, 1);
    cyc(1, 31'h7FFF_FFFE, 0);
    chk("R2 top legal seed", word, 64'h7FFF_FFFE);
    cyc(0, 0, 1);
    chk("R4 step from top", word, nxt(64'h7FFF_FFFE));

    cyc(1, 31'd777, 1);
    chk("R7 load beats step word", word, 777);
    chk("R7 load beats step valid", valid, 0);

    // Low half of the product all ones: end-around fold path.
    s = 31'(-inv_k());
    cyc(1, s, 0);
    cyc(0, 0, 1);
    chk("R4 all-ones low fold", word, nxt(64'(s)));

    // Random mix
    m = 64'(word);
    for (int i = 0; i < 400; i++) begin
      logic l, st, v;
      logic [30:0] rs;
      l  = ($urandom % 8) == 0;
      st = ($urandom % 4) != 0;
      case ($urandom % 6)
        0: rs = 31'd0;
        1: rs = 31'h7FFF_FFFF;
        default: rs = 31'($urandom);
      endcase
      if (l)       begin m = clean(rs); v = 0; end
      else if (st) begin m = nxt(m);    v = 1; end
      else         v = 0;
      cyc(l, rs, st);
      chk("R4 R2 R3 random word", word, m);
      chk("R5 random valid", valid, v);
      chk("R8 bit31 and range", {63'd0, (word[31] == 1'b0 && word != 0 && word != 32'h7FFF_FFFF)}, 1);
    end

    cyc(1, 31'd1, 0);
    for (int i = 0; i < 10000; i++) cyc(0, 0, 1);
    chk("R9 10000th word", word, 1043618065);

    finish_run();
  end
endmodule